// File: doc/BRIEF.md
# Banked 24-bit Address Generator

This block turns the 16-bit address state of a processor core into 24-bit bus addresses. The top byte of a bus address selects one of 256 banks of 64 KiB. The block holds two 8-bit bank registers:

- a code bank, used for instruction fetch and for jump targets;
- a data bank, used for absolute data accesses.

Each cycle the sequencer presents a 4-bit access mode together with the program counter, the selected index, the stack pointer, the direct page base and the instruction operand. The block answers in the same cycle with an address and a valid strobe.

The access classes differ in how they treat the 16-bit boundary:

- **Instruction fetch, branches and short jumps** wrap inside the current code bank.
- **Absolute indexed data** lets the index carry into the bank byte, so the access moves on into the next bank.
- **Long data** adds the index across the full 24 bits.
- **Stack, direct page and interrupt vector** accesses are always placed in bank zero.

A long jump reloads the code bank from its 24-bit operand. An interrupt vector fetch clears the code bank. Both bank registers can also be loaded directly through load strobes.

Top module: `banked_agen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears both the code bank and the data bank to 00h.
- R2: In a defined mode (0 to 8), code_ld loads bank_din into the code bank at the next edge, unless the mode itself sets the code bank. In a defined mode, data_ld loads bank_din into the data bank at the next edge.
- R3: Mode 0 (fetch) gives address {code bank, pc}.
- R4: Mode 1 (branch) gives {code bank, (pc + sign-extended opnd[7:0]) mod 2^16}. The result wraps inside the bank, and the code bank never changes because of a branch.
- R5: Mode 2 (short jump) gives {code bank, opnd[15:0]} and leaves the code bank unchanged.
- R6: Mode 3 (long jump) gives address opnd[23:0] and loads opnd[23:16] into the code bank at the next edge. This takes priority over code_ld.
- R7: Mode 4 (absolute data) gives ({data bank, opnd[15:0]} + idx) mod 2^24. A carry out of the low 16 bits increments the bank byte.
- R8: Mode 5 (long data) gives (opnd[23:0] + idx) mod 2^24.
- R9: Mode 6 (direct page) gives {00h, (dp + opnd[7:0] + idx) mod 2^16}.
- R10: Mode 7 (stack) gives {00h, (sp + opnd[7:0]) mod 2^16}.
- R11: Mode 8 (vector) gives {00h, opnd[15:0]} and clears the code bank at the next edge. This takes priority over code_ld.
- R12: Modes 9 to 15 drive valid low and leave both bank registers unchanged, even when code_ld or data_ld is high.
- R13: valid is high in every cycle with a mode from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Access mode code |
| pc_i | input | 16 | Program counter |
| idx_i | input | 16 | Selected index value (0 when none) |
| sp_i | input | 16 | Stack pointer |
| dp_i | input | 16 | Direct page base |
| opnd_i | input | 24 | Instruction operand |
| code_ld_i | input | 1 | Load strobe for the code bank |
| data_ld_i | input | 1 | Load strobe for the data bank |
| bank_din_i | input | 8 | Value for either load strobe |
| addr_o | output | 24 | Bus address |
| valid_o | output | 1 | Address valid strobe |
| code_bank_o | output | 8 | Current code bank |
| data_bank_o | output | 8 | Current data bank |

## Verification
The bench targets the places where each access class meets FFFFh:

- **Branch wrap.** A branch from FFFFh must return to 0000h in the same bank. A design that let the carry through would fetch from the next bank.
- **Absolute index carry.** An absolute index past FFFFh must land in the next bank. A wrapping design would reread the low end of the current bank.
- **Bank-zero classes.** Direct page and stack sums past FFFFh must stay in bank zero, so the code bank or data bank must not leak into their top byte.

The bench also checks that a long jump and a vector fetch both win over a simultaneous code-bank load. It checks that an undefined mode leaves both banks untouched while both load strobes are high. Finally, it mixes random cycles against the reference model to catch a wrong mode decode.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [3:0] {
        AM_FETCH     = 4'd0,
        AM_BRANCH    = 4'd1,
        AM_JMP_SHORT = 4'd2,
        AM_JMP_LONG  = 4'd3,
        AM_DATA_ABS  = 4'd4,
        AM_DATA_LONG = 4'd5,
        AM_DIRECT    = 4'd6,
        AM_STACK     = 4'd7,
        AM_VECTOR    = 4'd8
    } agen_mode_e;

    localparam logic [3:0] AM_LAST_DEFINED = 4'd8;

endpackage

// File: rtl/agen_bank_regs.sv
module agen_bank_regs #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_ok,
    input  logic              code_set,
    input  logic [BANK_W-1:0] code_set_val,
    input  logic              code_ld,
    input  logic              data_ld,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] code_bank,
    output logic [BANK_W-1:0] data_bank
);

    logic [BANK_W-1:0] code_nx;
    logic [BANK_W-1:0] data_nx;

    always_comb begin
        code_nx = code_bank;
        data_nx = data_bank;
        if (mode_ok) begin
            if (code_set) begin
                code_nx = code_set_val;
            end else if (code_ld) begin
                code_nx = din;
            end
            if (data_ld) begin
                data_nx = din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_bank <= '0;
            data_bank <= '0;
        end else begin
            code_bank <= code_nx;
            data_bank <= data_nx;
        end
    end

endmodule

// File: rtl/agen_addr_calc.sv
module agen_addr_calc
    import agen_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic [3:0]        mode,
    input  logic [BANK_W-1:0] code_bank,
    input  logic [BANK_W-1:0] data_bank,
    input  logic [OFS_W-1:0]  pc,
    input  logic [OFS_W-1:0]  idx,
    input  logic [OFS_W-1:0]  sp,
    input  logic [OFS_W-1:0]  dp,
    input  logic [ADDR_W-1:0] opnd,
    output logic [ADDR_W-1:0] addr,
    output logic              mode_ok,
    output logic              code_set,
    output logic [BANK_W-1:0] code_set_val
);

    localparam logic [BANK_W-1:0] BANK_ZERO = '0;

    agen_mode_e        mode_e;
    logic [OFS_W-1:0]  short8;
    logic [OFS_W-1:0]  branch_ofs;
    logic [OFS_W-1:0]  direct_ofs;
    logic [OFS_W-1:0]  stack_ofs;
    logic [ADDR_W-1:0] idx_wide;
    logic [ADDR_W-1:0] abs_base;

    assign mode_e     = agen_mode_e'(mode);
    assign short8     = {{(OFS_W-8){1'b0}}, opnd[7:0]};
    assign branch_ofs = pc + {{(OFS_W-8){opnd[7]}}, opnd[7:0]};
    assign direct_ofs = dp + short8 + idx;
    assign stack_ofs  = sp + short8;
    assign idx_wide   = {BANK_ZERO, idx};
    assign abs_base   = {data_bank, opnd[OFS_W-1:0]};

    always_comb begin
        addr         = '0;
        mode_ok      = 1'b1;
        code_set     = 1'b0;
        code_set_val = '0;
        unique case (mode_e)
            AM_FETCH:     addr = {code_bank, pc};
            AM_BRANCH:    addr = {code_bank, branch_ofs};
            AM_JMP_SHORT: addr = {code_bank, opnd[OFS_W-1:0]};
            AM_JMP_LONG: begin
                addr         = opnd;
                code_set     = 1'b1;
                code_set_val = opnd[ADDR_W-1:OFS_W];
            end
            AM_DATA_ABS:  addr = abs_base + idx_wide;
            AM_DATA_LONG: addr = opnd + idx_wide;
            AM_DIRECT:    addr = {BANK_ZERO, direct_ofs};
            AM_STACK:     addr = {BANK_ZERO, stack_ofs};
            AM_VECTOR: begin
                addr         = {BANK_ZERO, opnd[OFS_W-1:0]};
                code_set     = 1'b1;
                code_set_val = BANK_ZERO;
            end
            default:      mode_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/banked_agen.sv
module banked_agen #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        mode_i,
    input  logic [OFS_W-1:0]  pc_i,
    input  logic [OFS_W-1:0]  idx_i,
    input  logic [OFS_W-1:0]  sp_i,
    input  logic [OFS_W-1:0]  dp_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic              code_ld_i,
    input  logic              data_ld_i,
    input  logic [BANK_W-1:0] bank_din_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic [BANK_W-1:0] code_bank_o,
    output logic [BANK_W-1:0] data_bank_o
);

    logic              mode_ok;
    logic              code_set;
    logic [BANK_W-1:0] code_set_val;
    logic [BANK_W-1:0] code_bank;
    logic [BANK_W-1:0] data_bank;
    logic [ADDR_W-1:0] addr_raw;

    agen_addr_calc #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_calc (
        .mode         (mode_i),
        .code_bank    (code_bank),
        .data_bank    (data_bank),
        .pc           (pc_i),
        .idx          (idx_i),
        .sp           (sp_i),
        .dp           (dp_i),
        .opnd         (opnd_i),
        .addr         (addr_raw),
        .mode_ok      (mode_ok),
        .code_set     (code_set),
        .code_set_val (code_set_val)
    );

    agen_bank_regs #(.BANK_W(BANK_W)) u_banks (
        .clk          (clk),
        .rst          (rst),
        .mode_ok      (mode_ok),
        .code_set     (code_set),
        .code_set_val (code_set_val),
        .code_ld      (code_ld_i),
        .data_ld      (data_ld_i),
        .din          (bank_din_i),
        .code_bank    (code_bank),
        .data_bank    (data_bank)
    );

    assign addr_o      = addr_raw;
    assign valid_o     = mode_ok;
    assign code_bank_o = code_bank;
    assign data_bank_o = data_bank;

endmodule

// File: rtl/banked_agen_chk.sv
module banked_agen_chk #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        mode_i,
    input logic [OFS_W-1:0]  pc_i,
    input logic [ADDR_W-1:0] opnd_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              valid_o,
    input logic [BANK_W-1:0] code_bank_o,
    input logic [BANK_W-1:0] data_bank_o
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (code_bank_o == '0 && data_bank_o == '0));

    assert_fetch_in_bank_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd0) |-> (addr_o == {code_bank_o, pc_i}));

    assert_long_jump_bank_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd3) |=> (code_bank_o == $past(opnd_i[ADDR_W-1:OFS_W])));

    assert_direct_bank0_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd6) |-> (addr_o[ADDR_W-1:OFS_W] == '0));

    assert_stack_bank0_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd7) |-> (addr_o[ADDR_W-1:OFS_W] == '0));

    assert_vector_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd8) |=> (code_bank_o == '0));

    assert_bad_mode_invalid_R12: assert property (@(posedge clk) disable iff (rst)
        (mode_i > 4'd8) |-> !valid_o);

    assert_bad_mode_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mode_i > 4'd8) |=> ($stable(code_bank_o) && $stable(data_bank_o)));

    assert_good_mode_valid_R13: assert property (@(posedge clk) disable iff (rst)
        (mode_i <= 4'd8) |-> valid_o);

endmodule

bind banked_agen banked_agen_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .pc_i        (pc_i),
    .opnd_i      (opnd_i),
    .addr_o      (addr_o),
    .valid_o     (valid_o),
    .code_bank_o (code_bank_o),
    .data_bank_o (data_bank_o)
);

// File: tb/banked_agen_tb.sv
module banked_agen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mode_i;
    logic [15:0] pc_i, idx_i, sp_i, dp_i;
    logic [23:0] opnd_i;
    logic        code_ld_i, data_ld_i;
    logic [7:0]  bank_din_i;
    logic [23:0] addr_o;
    logic        valid_o;
    logic [7:0]  code_bank_o, data_bank_o;

    int checks = 0;
    int failures = 0;
    int m_code = 0;
    int m_data = 0;

    always #10 clk = ~clk;

    banked_agen u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .pc_i(pc_i), .idx_i(idx_i),
        .sp_i(sp_i), .dp_i(dp_i), .opnd_i(opnd_i), .code_ld_i(code_ld_i),
        .data_ld_i(data_ld_i), .bank_din_i(bank_din_i), .addr_o(addr_o),
        .valid_o(valid_o), .code_bank_o(code_bank_o), .data_bank_o(data_bank_o)
    );

    function automatic string req_of(int m);
        case (m)
            0: return "R3";  1: return "R4";  2: return "R5";
            3: return "R6";  4: return "R7";  5: return "R8";
            6: return "R9";  7: return "R10"; 8: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic int exp_addr(int m);
        int off;
        off = int'(opnd_i[7:0]);
        if (off > 127) off = off - 256;
        case (m)
            0: return (m_code * 65536) + int'(pc_i);
            1: return (m_code * 65536) + ((int'(pc_i) + off) & 16'hFFFF);
            2: return (m_code * 65536) + int'(opnd_i[15:0]);
            3: return int'(opnd_i);
            4: return ((m_data * 65536) + int'(opnd_i[15:0]) + int'(idx_i)) & 24'hFFFFFF;
            5: return (int'(opnd_i) + int'(idx_i)) & 24'hFFFFFF;
            6: return (int'(dp_i) + int'(opnd_i[7:0]) + int'(idx_i)) & 16'hFFFF;
            7: return (int'(sp_i) + int'(opnd_i[7:0])) & 16'hFFFF;
            8: return int'(opnd_i[15:0]);
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive inputs on the falling edge, compare mid-phase, then step the model at the rising edge.
    task automatic step(int m, logic [15:0] pc, logic [15:0] idx, logic [15:0] sp,
                        logic [15:0] dp, logic [23:0] op, bit cld, bit dld, logic [7:0] din);
        mode_i = 4'(m); pc_i = pc; idx_i = idx; sp_i = sp; dp_i = dp; opnd_i = op;
        code_ld_i = cld; data_ld_i = dld; bank_din_i = din;
        #5;
        chk("R13/R12", "valid", int'(valid_o), (m <= 8) ? 1 : 0);
        if (m <= 8) chk(req_of(m), "addr", int'(addr_o), exp_addr(m));
        chk("R2", "code bank", int'(code_bank_o), m_code);
        chk("R2", "data bank", int'(data_bank_o), m_data);
        @(posedge clk);
        if (m <= 8) begin
            if (m == 3) m_code = int'(op[23:16]);
            else if (m == 8) m_code = 0;
            else if (cld) m_code = int'(din);
            if (dld) m_data = int'(din);
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_i = 4'd15; pc_i = '0; idx_i = '0; sp_i = '0; dp_i = '0;
        opnd_i = '0; code_ld_i = 1'b0; data_ld_i = 1'b0; bank_din_i = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "code bank after reset", int'(code_bank_o), 0);
        chk("R1", "data bank after reset", int'(data_bank_o), 0);
        rst = 1'b0;

        // R2: load both banks
        step(0, 16'h1234, 0, 0, 0, 0, 1, 0, 8'h05);
        step(0, 16'h1234, 0, 0, 0, 0, 0, 1, 8'h12);
        // R3 fetch, R4 branch wrap forward and backward
        step(0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
        step(1, 16'hFFFF, 0, 0, 0, 24'h000001, 0, 0, 0);
        step(1, 16'h0002, 0, 0, 0, 24'h0000FC, 0, 0, 0);
        // R5 short jump keeps bank
        step(2, 16'h0000, 0, 0, 0, 24'hAB4321, 0, 0, 0);
        // R7 absolute index carries into next bank
        step(4, 0, 16'h0020, 0, 0, 24'h00FFF0, 0, 0, 0);
        // R8 long index wraps modulo 2^24
        step(5, 0, 16'h0020, 0, 0, 24'hFFFFF0, 0, 0, 0);
        // R9 direct page wraps inside bank zero, R10 stack too
        step(6, 0, 16'h0010, 0, 16'hFFF0, 24'h000010, 0, 0, 0);
        step(7, 0, 0, 16'hFFFF, 0, 24'h000003, 0, 0, 0);
        // R6 long jump wins over code_ld
        step(3, 0, 0, 0, 0, 24'h7E8000, 1, 0, 8'h33);
        step(0, 16'h0100, 0, 0, 0, 0, 0, 0, 0);
        // R11 vector clears code bank, wins over code_ld
        step(8, 0, 0, 0, 0, 24'h40FFEA, 1, 0, 8'h44);
        step(0, 16'h0200, 0, 0, 0, 0, 0, 0, 0);
        // R12 undefined modes ignore both strobes
        step(9, 0, 0, 0, 0, 0, 1, 1, 8'h99);
        step(15, 0, 0, 0, 0, 0, 1, 1, 8'hEE);
        step(0, 16'h0300, 0, 0, 0, 0, 0, 0, 0);

        // Mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom % 16), 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 24'($urandom), bit'($urandom % 4 == 0),
                 bit'($urandom % 4 == 0), 8'($urandom));
        end

        // R1 reset again from nonzero banks
        step(0, 0, 0, 0, 0, 0, 1, 1, 8'hA5);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_code = 0; m_data = 0;
        chk("R1", "code bank after second reset", int'(code_bank_o), 0);
        chk("R1", "data bank after second reset", int'(data_bank_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule